// File: doc/BRIEF.md
# Bit-Serial Shift-Register Adder

This block adds two unsigned operands of `W` bits (default 8) by working through them one bit position per clock, least significant position first. Two operand registers are loaded in parallel while the block is idle. A start pulse then runs `W` shift cycles. In each cycle a single full adder combines the low bit of each register with a stored carry. The sum bit enters the accumulator register at its top end, so that register holds the complete sum once the last shift is done. The carry out of the top position stays in the carry flip-flop and is driven out as the final carry.

The hardware cost is one full adder, one carry flip-flop and a small bit counter, whatever the width. In exchange, an addition takes `W` clocks instead of one. The accumulator is always visible on the result bus. After a load it shows the first operand, and after a finished run it shows the sum. By default the second operand register fills with zeros as it shifts. A parameter can select recirculation instead, which puts the operand back in its register when the run ends.

Top module: `sadd_top`

## Requirements
- R1: While reset is high and on the cycle after it, `busy`, `done` and `carry_out` are 0 and `sum` is all zeros.
- R2: A `load` pulse taken while idle copies `opa` into the accumulator and `opb` into the second register. `sum` equals `opa` from the next cycle on and stays unchanged while the block is idle with `load` low.
- R3: A `start` pulse taken while idle with `load` low raises `busy` on the next cycle. `busy` stays high for exactly `W` cycles.
- R4: In the cycle where `done` is high, `sum` equals (A + B) mod 2^W and `carry_out` equals bit W of A + B. Here A and B are the loaded operands, and the positions are added least significant first.
- R5: A `start` pulse given while `busy` is high is ignored. The run ends at its original time with the original result.
- R6: A `load` pulse given while `busy` is high is ignored. The run ends at its original time with the original result.
- R7: The carry flip-flop is cleared when a run starts. With the default zero fill, a second start with no reload in between leaves `sum` unchanged and gives `carry_out` 0.
- R8: `done` is high for exactly one cycle, on the cycle right after the last `busy` cycle. `busy` is low while `done` is high.
- R9: When `load` and `start` are high together while idle, the load is taken, the start is ignored and `busy` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Parallel load strobe for both operands |
| opa | input | W | First operand, accumulator load value |
| opb | input | W | Second operand |
| start | input | 1 | Begin a serial addition |
| busy | output | 1 | High while shift cycles run |
| done | output | 1 | One-cycle completion pulse |
| sum | output | W | Accumulator contents, the sum after completion |
| carry_out | output | 1 | Carry flip-flop, final carry after completion |

## Verification
Let edge k be the edge that samples a start pulse. `busy` becomes visible after edge k, and the `W` shifts happen on edges k+1 to k+W. `done`, `sum` and `carry_out` are then due together after edge k+W, and `done` falls after edge k+W+1. A loaded operand shows on `sum` one edge after the load. The bench drives and samples on falling edges. After a start it counts exactly `W-1` further falling edges with `busy` high before it expects `done`, so a result that comes early or late is reported. Random operand pairs from a fixed seed are mixed with directed cases: all ones plus all ones, zero plus zero, all ones plus one, and stray start and load pulses in the middle of a run.

// File: rtl/sadd_pkg.sv
package sadd_pkg;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic s;
        logic c;
    } fa_out_t;

endpackage

// File: rtl/sadd_fa.sv
module sadd_fa
    import sadd_pkg::*;
(
    input  logic    a,
    input  logic    b,
    input  logic    ci,
    output fa_out_t o
);

    logic half;

    always_comb begin
        half = a ^ b;
        o.s  = half ^ ci;
        o.c  = (a & b) | (ci & half);
    end

endmodule

// File: rtl/sadd_shreg.sv
module sadd_shreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         ser_in,
    output logic [W-1:0] q
);

    typedef struct packed {
        logic [W-1:0] data;
    } sr_t;

    sr_t sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (load) begin
            sr_d.data = load_val;
        end else if (shift) begin
            sr_d.data = {ser_in, sr_q.data[W-1:1]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= '0;
        end else begin
            sr_q <= sr_d;
        end
    end

    assign q = sr_q.data;

endmodule

// File: rtl/sadd_seq.sv
module sadd_seq
    import sadd_pkg::*;
#(
    parameter int W = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic load,
    output logic busy,
    output logic done,
    output logic shift_en,
    output logic carry_clr,
    output logic load_en
);

    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    typedef struct packed {
        seq_state_e    st;
        logic [CW-1:0] cnt;
        logic          done;
    } seq_t;

    seq_t s_d, s_q;
    logic idle;
    logic go;

    always_comb begin
        idle      = (s_q.st == SEQ_IDLE);
        go        = idle && start && !load;
        load_en   = idle && load;
        carry_clr = go;
        shift_en  = (s_q.st == SEQ_RUN);

        s_d       = s_q;
        s_d.done  = 1'b0;
        unique case (s_q.st)
            SEQ_IDLE: begin
                if (go) begin
                    s_d.st  = SEQ_RUN;
                    s_d.cnt = '0;
                end
            end
            SEQ_RUN: begin
                if (s_q.cnt == LAST) begin
                    s_d.st   = SEQ_IDLE;
                    s_d.done = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            default: s_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '{st: SEQ_IDLE, cnt: '0, done: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy = shift_en;
    assign done = s_q.done;

endmodule

// File: rtl/sadd_top.sv
module sadd_top
    import sadd_pkg::*;
#(
    parameter int W        = 8,
    parameter bit B_RECIRC = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic         start,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] sum,
    output logic         carry_out
);

    typedef struct packed {
        logic cy;
    } cy_t;

    logic         shift_en;
    logic         carry_clr;
    logic         load_en;
    logic [W-1:0] a_q;
    logic [W-1:0] b_q;
    logic         b_ser;
    fa_out_t      fa_o;
    cy_t          cy_d, cy_q;

    sadd_seq #(.W(W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .load      (load),
        .busy      (busy),
        .done      (done),
        .shift_en  (shift_en),
        .carry_clr (carry_clr),
        .load_en   (load_en)
    );

    sadd_fa u_fa (
        .a  (a_q[0]),
        .b  (b_q[0]),
        .ci (cy_q.cy),
        .o  (fa_o)
    );

    sadd_shreg #(.W(W)) u_acc (
        .clk      (clk),
        .rst      (rst),
        .load     (load_en),
        .load_val (opa),
        .shift    (shift_en),
        .ser_in   (fa_o.s),
        .q        (a_q)
    );

    generate
        if (B_RECIRC) begin : g_b_recirc
            assign b_ser = b_q[0];
        end else begin : g_b_zero
            assign b_ser = 1'b0;
        end
    endgenerate

    sadd_shreg #(.W(W)) u_opb (
        .clk      (clk),
        .rst      (rst),
        .load     (load_en),
        .load_val (opb),
        .shift    (shift_en),
        .ser_in   (b_ser),
        .q        (b_q)
    );

    always_comb begin
        cy_d = cy_q;
        if (carry_clr) begin
            cy_d.cy = 1'b0;
        end else if (shift_en) begin
            cy_d.cy = fa_o.c;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cy_q <= '0;
        end else begin
            cy_q <= cy_d;
        end
    end

    assign sum       = a_q;
    assign carry_out = cy_q.cy;

endmodule

// File: rtl/sadd_chk.sv
module sadd_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         load,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] sum,
    input logic         carry_out
);

    localparam int RW = $clog2(W + 1) + 1;

    logic [RW-1:0] run_len;

    always_ff @(posedge clk) begin
        if (rst || !busy) begin
            run_len <= '0;
        end else begin
            run_len <= run_len + 1'b1;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!busy && !done && !carry_out && sum == '0)); // R1

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!busy && !load) |=> $stable(sum)); // R2

    AST_START_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && !load) |=> busy); // R3

    AST_RUN_BOUND: assert property (@(posedge clk) disable iff (rst)
        busy |-> (run_len < RW'(W))); // R3

    AST_RUN_FULL: assert property (@(posedge clk) disable iff (rst)
        (busy && run_len == RW'(W - 1)) |=> (!busy && done)); // R8

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R8

    AST_BOTH_NO_RUN: assert property (@(posedge clk) disable iff (rst)
        (load && start && !busy) |=> !busy); // R9

endmodule

bind sadd_top sadd_chk #(.W(W)) u_sadd_chk (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .sum       (sum),
    .carry_out (carry_out)
);

// File: tb/sadd_top_test.sv
module sadd_top_test;

    localparam int W = 8;
    localparam logic [W-1:0] ONES = '1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         load = 1'b0;
    logic [W-1:0] opa = '0;
    logic [W-1:0] opb = '0;
    logic         start = 1'b0;
    logic         busy;
    logic         done;
    logic [W-1:0] sum;
    logic         carry_out;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    sadd_top #(.W(W)) uut (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .opa       (opa),
        .opb       (opb),
        .start     (start),
        .busy      (busy),
        .done      (done),
        .sum       (sum),
        .carry_out (carry_out)
    );

    function automatic logic [W:0] ref_add(logic [W-1:0] a, logic [W-1:0] b);
        return {1'b0, a} + {1'b0, b};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_load(input logic [W-1:0] a, input logic [W-1:0] b);
        @(negedge clk);
        load = 1'b1; opa = a; opb = b;
        @(negedge clk);
        load = 1'b0;
        chk(sum == a, "R2 load", 64'(sum), 64'(a));
    endtask

    // run an add; stray: 0 none, 1 start mid-run (R5), 2 load mid-run (R6)
    task automatic do_run(input logic [W-1:0] exp_s, input logic exp_c,
                          input int stray);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R3 busy after start", 64'(busy), 64'd1);
        for (int i = 0; i < W - 1; i++) begin
            if (i == 2 && stray == 1) start = 1'b1;
            if (i == 2 && stray == 2) begin
                load = 1'b1; opa = ~exp_s; opb = 8'h5A;
            end
            @(negedge clk);
            start = 1'b0; load = 1'b0;
            chk(busy && !done, "R3 busy held", 64'({busy, done}), 64'b10);
        end
        @(negedge clk);
        chk(!busy && done, "R8 done after W", 64'({busy, done}), 64'b01);
        chk(sum == exp_s, stray == 1 ? "R5 sum" : (stray == 2 ? "R6 sum" : "R4 sum"),
            64'(sum), 64'(exp_s));
        chk(carry_out == exp_c, "R4 carry", 64'(carry_out), 64'(exp_c));
        @(negedge clk);
        chk(!done && !busy, "R8 done single", 64'({busy, done}), 64'b00);
        chk(sum == exp_s, "R2 idle hold", 64'(sum), 64'(exp_s));
    endtask

    task automatic add_pair(input logic [W-1:0] a, input logic [W-1:0] b,
                            input int stray);
        logic [W:0] r;
        r = ref_add(a, b);
        do_load(a, b);
        do_run(r[W-1:0], r[W], stray);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk(!busy && !done && !carry_out && sum == '0, "R1 in reset",
            64'({busy, done, carry_out, sum}), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !carry_out && sum == '0, "R1 after reset",
            64'({busy, done, carry_out, sum}), 64'd0);

        // directed corners
        add_pair(ONES, ONES, 0);
        add_pair('0, '0, 0);
        add_pair(ONES, 8'd1, 0);
        add_pair(8'h0F, 8'hF0, 0);

        // R7: carry from previous run (1) must be cleared; B is zero now
        add_pair(8'hC3, 8'h81, 0);
        do_run(8'h44, 1'b0, 0); // R7

        // R5 / R6 stray pulses during a run
        add_pair(8'h9D, 8'h77, 1);
        add_pair(8'h21, 8'hE8, 2);

        // R9: load and start together
        @(negedge clk);
        load = 1'b1; start = 1'b1; opa = 8'h3C; opb = 8'h11;
        @(negedge clk);
        load = 1'b0; start = 1'b0;
        chk(!busy && sum == 8'h3C, "R9 load wins", 64'({busy, sum}), 64'h3C);
        @(negedge clk);
        chk(!busy && !done, "R9 no run", 64'({busy, done}), 64'd0);
        do_run(8'h4D, 1'b0, 0);

        // constrained random
        for (int k = 0; k < 200; k++) begin
            logic [W-1:0] ra, rb;
            ra = W'($urandom);
            rb = W'($urandom);
            if (k % 10 == 0) ra = ONES;
            add_pair(ra, rb, k % 3);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule